// File: doc/BRIEF.md
# Receive Descriptor Writer

This block takes an incoming frame as a byte stream and stores it in system memory through a chain of receive descriptors. Each descriptor is a 16-byte header followed at once by its data area. The header holds a status halfword, a control halfword, a link word, a buffer pointer word that is not used in this mode, and two halfwords: the number of bytes actually stored and the capacity of the data area. Software builds the chain, writes a start command with the address of the first descriptor, and then waits for frame interrupts. Each frame uses exactly one descriptor.

Before a frame arrives, the unit reads the header of the next descriptor. It writes the frame bytes one at a time into the data area. At the end of the frame it writes the stored byte count and then the status halfword, which carries the complete, ok, overrun and short-frame flags. It then follows the link to the next descriptor. If the control halfword has its end-of-chain flag set, the unit stops in a no-resources state and raises a separate interrupt. It stays there until software issues a new start. A frame that arrives while no descriptor is loaded is thrown away as a whole and counted.

Top module: `rx_desc_writer`

## Requirements
- R1: After reset the receive state is idle (0), the interrupt status is 0, the drop counter is 0, and no memory read or write is issued.
- R2: A command with code 1 loads the descriptor address from `cmd_addr` and moves the reported state to ready (4) on the next cycle. This only happens when the unit is idle or in no-resources and no dropped frame is in progress. Other codes are ignored, and a start while ready is ignored.
- R3: The header is fetched with three word reads at offsets 0, 4 and 12 from the descriptor base. Read data arrives one cycle after `mem_rd_en`, little-endian. Control is bits 31:16 of word 0, the link is word 4, and the data-area capacity is bits 31:16 of word 12.
- R4: Frame byte i is written as a byte write (`mem_wr_len` 0) to base + 16 + i.
- R5: At frame end the unit writes the stored count as a halfword (`mem_wr_len` 1) to base + 12. It then writes the status halfword to base + 0, with bit 15 set and bit 13 set for a good frame.
- R6: Bytes beyond the data-area capacity are not written. The stored count equals the capacity, status bit 8 is set, and bit 13 is clear.
- R7: An error flag on any byte of the frame sets status bit 7 and clears bit 13.
- R8: After a descriptor whose control bit 15 is clear, the unit fetches the descriptor at its link address.
- R9: After filling a descriptor whose control bit 15 is set, the state becomes no-resources (2) and interrupt bit 4 is raised.
- R10: Every completed frame sets interrupt bit 6. Interrupt bits are sticky and cleared by writing 1 to `irq_ack`. A set in the same cycle wins over a clear.
- R11: While idle or in no-resources, `rx_ready` is high and incoming bytes are discarded without any memory write. Each discarded frame adds 1 to the drop counter when its last byte is taken.
- R12: A start issued from no-resources resumes storage at the new descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 3 | Command code, 1 = start |
| cmd_addr | input | AW | First descriptor address for start |
| irq_ack | input | 8 | Write-1-to-clear mask for interrupt bits |
| rx_valid | input | 1 | Stream byte valid |
| rx_data | input | 8 | Stream byte |
| rx_last | input | 1 | Last byte of frame |
| rx_err | input | 1 | Short-frame error flag |
| rx_ready | output | 1 | Byte taken when high with rx_valid |
| mem_rd_en | output | 1 | Header word read request |
| mem_rd_addr | output | AW | Read byte address |
| mem_rd_data | input | 32 | Read word, one cycle after request |
| mem_wr_en | output | 1 | Write request |
| mem_wr_len | output | 2 | 0 byte, 1 halfword, 2 word |
| mem_wr_addr | output | AW | Write byte address |
| mem_wr_data | output | 32 | Write data, right-aligned |
| ru_state | output | 4 | 0 idle, 2 no-resources, 4 ready |
| irq_status | output | 8 | Sticky interrupt bits |
| drop_cnt | output | CW | Discarded frame count |

## Verification
If the descriptor base or the capture of the link went wrong, the very next header read would go to an address the scoreboard does not expect, within three cycles of a frame's status write. A wrong byte counter or a wrong capacity register would show up as an out-of-place byte write, or as a wrong count halfword, on the cycle the last byte is taken plus one. If the end-of-chain flag were lost, reads to the link address would appear where the state should instead settle at no-resources. If drop tracking were broken, writes would occur during a discarded frame, or the counter would be off by the time the frame's last byte is consumed.

// File: rtl/rx_desc_pkg.sv
package rx_desc_pkg;
    typedef enum logic [3:0] {
        ST_IDLE, ST_RD0, ST_RD1, ST_RD2, ST_RD3,
        ST_RECV, ST_WSIZE, ST_WSTAT, ST_NORES
    } rdw_state_e;

    localparam logic [1:0] WR_BYTE = 2'd0;
    localparam logic [1:0] WR_HALF = 2'd1;

    localparam int unsigned HDR_BYTES = 16;
    localparam int unsigned OFS_LINK  = 4;
    localparam int unsigned OFS_SIZE  = 12;
    localparam int unsigned SZ_W      = 16;

    localparam logic [2:0] CMD_START = 3'd1;

    localparam logic [3:0] RU_IDLE  = 4'd0;
    localparam logic [3:0] RU_NORES = 4'd2;
    localparam logic [3:0] RU_READY = 4'd4;

    localparam int IRQ_FRAME_BIT = 6;
    localparam int IRQ_NORES_BIT = 4;

    localparam int SB_DONE  = 15;
    localparam int SB_GOOD  = 13;
    localparam int SB_OVR   = 8;
    localparam int SB_SHORT = 7;
    localparam int CB_END   = 15;
endpackage

// File: rtl/rdw_stat_word.sv
module rdw_stat_word
    import rx_desc_pkg::*;
(
    input  logic              ovf,
    input  logic              err,
    output logic [SZ_W-1:0]   word
);
    always_comb begin
        word           = '0;
        word[SB_DONE]  = 1'b1;
        word[SB_GOOD]  = ~(ovf | err);
        word[SB_OVR]   = ovf;
        word[SB_SHORT] = err;
    end
endmodule

// File: rtl/rdw_irq_latch.sv
module rdw_irq_latch #(
    parameter int IW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] set_i,
    input  logic [IW-1:0] ack_i,
    output logic [IW-1:0] q_o
);
    logic [IW-1:0] irq_d, irq_q;

    always_comb irq_d = (irq_q & ~ack_i) | set_i;

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_d;
    end

    assign q_o = irq_q;
endmodule

// File: rtl/rdw_drop_cnt.sv
module rdw_drop_cnt #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc_i,
    output logic [CW-1:0] q_o
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb cnt_d = inc_i ? cnt_q + 1'b1 : cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign q_o = cnt_q;
endmodule

// File: rtl/rx_desc_writer.sv
module rx_desc_writer
    import rx_desc_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 32,
    parameter int IW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_code,
    input  logic [AW-1:0] cmd_addr,
    input  logic [IW-1:0] irq_ack,
    input  logic          rx_valid,
    input  logic [7:0]    rx_data,
    input  logic          rx_last,
    input  logic          rx_err,
    output logic          rx_ready,
    output logic          mem_rd_en,
    output logic [AW-1:0] mem_rd_addr,
    input  logic [31:0]   mem_rd_data,
    output logic          mem_wr_en,
    output logic [1:0]    mem_wr_len,
    output logic [AW-1:0] mem_wr_addr,
    output logic [31:0]   mem_wr_data,
    output logic [3:0]    ru_state,
    output logic [IW-1:0] irq_status,
    output logic [CW-1:0] drop_cnt
);
    localparam logic [AW-1:0] HDR_OFS  = AW'(HDR_BYTES);
    localparam logic [AW-1:0] LINK_OFS = AW'(OFS_LINK);
    localparam logic [AW-1:0] SIZE_OFS = AW'(OFS_SIZE);

    typedef struct packed {
        rdw_state_e       st;
        logic [AW-1:0]    base;
        logic [AW-1:0]    link;
        logic             last_desc;
        logic [SZ_W-1:0]  cap;
        logic [SZ_W-1:0]  cnt;
        logic             ovf;
        logic             err;
        logic             dropping;
    } regs_t;

    regs_t r_d, r_q;

    logic [IW-1:0]   irq_set;
    logic            drop_inc;
    logic [SZ_W-1:0] stat_word;
    logic            start_req;

    rdw_stat_word u_stat (
        .ovf  (r_q.ovf),
        .err  (r_q.err),
        .word (stat_word)
    );

    rdw_irq_latch #(.IW(IW)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (irq_set),
        .ack_i (irq_ack),
        .q_o   (irq_status)
    );

    rdw_drop_cnt #(.CW(CW)) u_drop (
        .clk   (clk),
        .rst_n (rst_n),
        .inc_i (drop_inc),
        .q_o   (drop_cnt)
    );

    assign start_req = cmd_valid && (cmd_code == CMD_START);

    always_comb begin
        r_d         = r_q;
        rx_ready    = 1'b0;
        mem_rd_en   = 1'b0;
        mem_rd_addr = '0;
        mem_wr_en   = 1'b0;
        mem_wr_len  = WR_BYTE;
        mem_wr_addr = '0;
        mem_wr_data = '0;
        irq_set     = '0;
        drop_inc    = 1'b0;

        unique case (r_q.st)
            ST_IDLE, ST_NORES: begin
                // no descriptor loaded: swallow the stream
                rx_ready = 1'b1;
                if (rx_valid) begin
                    if (rx_last) begin
                        drop_inc   = 1'b1;
                        r_d.dropping = 1'b0;
                    end else begin
                        r_d.dropping = 1'b1;
                    end
                end
                if (start_req && !r_q.dropping && !(rx_valid && !rx_last)) begin
                    r_d.base = cmd_addr;
                    r_d.st   = ST_RD0;
                end
            end
            ST_RD0: begin
                mem_rd_en   = 1'b1;
                mem_rd_addr = r_q.base;
                r_d.cnt     = '0;
                r_d.ovf     = 1'b0;
                r_d.err     = 1'b0;
                r_d.st      = ST_RD1;
            end
            ST_RD1: begin
                mem_rd_en     = 1'b1;
                mem_rd_addr   = r_q.base + LINK_OFS;
                r_d.last_desc = mem_rd_data[16 + CB_END];
                r_d.st        = ST_RD2;
            end
            ST_RD2: begin
                mem_rd_en   = 1'b1;
                mem_rd_addr = r_q.base + SIZE_OFS;
                r_d.link    = mem_rd_data;
                r_d.st      = ST_RD3;
            end
            ST_RD3: begin
                r_d.cap = mem_rd_data[16 +: SZ_W];
                r_d.st  = ST_RECV;
            end
            ST_RECV: begin
                rx_ready = 1'b1;
                if (rx_valid) begin
                    r_d.err = r_q.err | rx_err;
                    if (r_q.cnt < r_q.cap) begin
                        mem_wr_en   = 1'b1;
                        mem_wr_len  = WR_BYTE;
                        mem_wr_addr = r_q.base + HDR_OFS + AW'(r_q.cnt);
                        mem_wr_data = {24'd0, rx_data};
                        r_d.cnt     = r_q.cnt + 1'b1;
                    end else begin
                        r_d.ovf = 1'b1;
                    end
                    if (rx_last) r_d.st = ST_WSIZE;
                end
            end
            ST_WSIZE: begin
                mem_wr_en   = 1'b1;
                mem_wr_len  = WR_HALF;
                mem_wr_addr = r_q.base + SIZE_OFS;
                mem_wr_data = {{(32-SZ_W){1'b0}}, r_q.cnt};
                r_d.st      = ST_WSTAT;
            end
            ST_WSTAT: begin
                mem_wr_en              = 1'b1;
                mem_wr_len             = WR_HALF;
                mem_wr_addr            = r_q.base;
                mem_wr_data            = {{(32-SZ_W){1'b0}}, stat_word};
                irq_set[IRQ_FRAME_BIT] = 1'b1;
                if (r_q.last_desc) begin
                    irq_set[IRQ_NORES_BIT] = 1'b1;
                    r_d.st                 = ST_NORES;
                end else begin
                    r_d.base = r_q.link;
                    r_d.st   = ST_RD0;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, default: '0};
        else        r_q <= r_d;
    end

    always_comb begin
        unique case (r_q.st)
            ST_IDLE:  ru_state = RU_IDLE;
            ST_NORES: ru_state = RU_NORES;
            default:  ru_state = RU_READY;
        endcase
    end

    logic [AW-1:0]   chk_base;
    logic [SZ_W-1:0] chk_cap;
    logic            chk_dropping;
    assign chk_base     = r_q.base;
    assign chk_cap      = r_q.cap;
    assign chk_dropping = r_q.dropping;
endmodule

// File: rtl/rx_desc_writer_chk.sv
module rx_desc_writer_chk
    import rx_desc_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 32,
    parameter int IW = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cmd_valid,
    input logic [2:0]      cmd_code,
    input logic            rx_valid,
    input logic            rx_last,
    input logic            rx_ready,
    input logic            mem_wr_en,
    input logic [1:0]      mem_wr_len,
    input logic [AW-1:0]   mem_wr_addr,
    input logic [3:0]      ru_state,
    input logic [IW-1:0]   irq_status,
    input logic [CW-1:0]   drop_cnt,
    input logic [AW-1:0]   base,
    input logic [SZ_W-1:0] cap,
    input logic            dropping
);
    logic taken_drop;
    assign taken_drop = rx_valid && rx_last && rx_ready && (ru_state != RU_READY);

    assert_state_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ru_state == RU_IDLE) || (ru_state == RU_NORES) || (ru_state == RU_READY));

    assert_start_moves_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ru_state == RU_IDLE && cmd_valid && cmd_code == CMD_START && !rx_valid && !dropping)
        |=> ru_state == RU_READY);

    assert_byte_in_area_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_en && mem_wr_len == WR_BYTE)
        |-> (mem_wr_addr >= base + AW'(HDR_BYTES)) &&
            (mem_wr_addr <  base + AW'(HDR_BYTES) + AW'(cap)));

    assert_nores_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_status[IRQ_NORES_BIT]) |-> ru_state == RU_NORES);

    assert_nores_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ru_state == RU_NORES |-> rx_ready);

    assert_no_write_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ru_state != RU_READY |-> !mem_wr_en);

    assert_drop_inc_R11: assert property (@(posedge clk) disable iff (!rst_n)
        taken_drop |=> drop_cnt == $past(drop_cnt) + 1'b1);

    assert_drop_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !taken_drop |=> $stable(drop_cnt));
endmodule

bind rx_desc_writer rx_desc_writer_chk #(.AW(AW), .CW(CW), .IW(IW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_code   (cmd_code),
    .rx_valid   (rx_valid),
    .rx_last    (rx_last),
    .rx_ready   (rx_ready),
    .mem_wr_en  (mem_wr_en),
    .mem_wr_len (mem_wr_len),
    .mem_wr_addr(mem_wr_addr),
    .ru_state   (ru_state),
    .irq_status (irq_status),
    .drop_cnt   (drop_cnt),
    .base       (chk_base),
    .cap        (chk_cap),
    .dropping   (chk_dropping)
);

// File: tb/rx_desc_writer_bench.sv
module rx_desc_writer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_code = '0;
    logic [31:0] cmd_addr = '0;
    logic [7:0]  irq_ack = '0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_last = 1'b0;
    logic        rx_err = 1'b0;
    logic        rx_ready;
    logic        mem_rd_en;
    logic [31:0] mem_rd_addr;
    logic [31:0] mem_rd_data = '0;
    logic        mem_wr_en;
    logic [1:0]  mem_wr_len;
    logic [31:0] mem_wr_addr;
    logic [31:0] mem_wr_data;
    logic [3:0]  ru_state;
    logic [7:0]  irq_status;
    logic [31:0] drop_cnt;

    always #5 clk = ~clk;

    rx_desc_writer u_rx_desc_writer (.*);

    logic [7:0] mem [0:2047];
    int checks = 0;
    int errors = 0;

    logic [65:0] wq[$];
    string       wtag[$];
    logic [31:0] rq[$];
    string       rtag[$];

    task automatic chk(input bit ok, input string tag, input logic [71:0] act, input logic [71:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // memory model: one-cycle read latency, little-endian
    always @(posedge clk) begin
        if (mem_rd_en)
            mem_rd_data <= {mem[mem_rd_addr[10:0]+11'd3], mem[mem_rd_addr[10:0]+11'd2],
                            mem[mem_rd_addr[10:0]+11'd1], mem[mem_rd_addr[10:0]]};
        if (mem_wr_en) begin
            mem[mem_wr_addr[10:0]] <= mem_wr_data[7:0];
            if (mem_wr_len != 2'd0) mem[mem_wr_addr[10:0]+11'd1] <= mem_wr_data[15:8];
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_wr_en) begin
                if (wq.size() == 0)
                    chk(0, "R11 unexpected write", {6'd0, mem_wr_len, mem_wr_addr, mem_wr_data}, 0);
                else begin
                    logic [65:0] e;
                    string t;
                    e = wq.pop_front();
                    t = wtag.pop_front();
                    chk({mem_wr_len, mem_wr_addr, mem_wr_data} == e, t,
                        {6'd0, mem_wr_len, mem_wr_addr, mem_wr_data}, {6'd0, e});
                end
            end
            if (mem_rd_en) begin
                if (rq.size() == 0)
                    chk(0, "R2 unexpected read", {40'd0, mem_rd_addr}, 0);
                else begin
                    logic [31:0] a;
                    string t;
                    a = rq.pop_front();
                    t = rtag.pop_front();
                    chk(mem_rd_addr == a, t, {40'd0, mem_rd_addr}, {40'd0, a});
                end
            end
        end
    end

    task automatic put16(input int a, input logic [15:0] v);
        mem[a] = v[7:0]; mem[a+1] = v[15:8];
    endtask
    task automatic put32(input int a, input logic [31:0] v);
        put16(a, v[15:0]); put16(a+2, v[31:16]);
    endtask
    task automatic make_desc(input int a, input logic [15:0] ctl, input logic [31:0] lnk, input logic [15:0] cap);
        put16(a, 16'h0); put16(a+2, ctl); put32(a+4, lnk); put32(a+8, 32'h0);
        put16(a+12, 16'h0); put16(a+14, cap);
    endtask

    task automatic exp_fetch(input logic [31:0] a, input string t);
        rq.push_back(a);        rtag.push_back(t);
        rq.push_back(a + 4);    rtag.push_back(t);
        rq.push_back(a + 12);   rtag.push_back(t);
    endtask

    task automatic exp_frame(input logic [31:0] a, input int cap, input int n, input int seed,
                             input bit err, input string t);
        int stored;
        logic [15:0] st;
        stored = (n < cap) ? n : cap;
        for (int i = 0; i < stored; i++) begin
            wq.push_back({2'd0, a + 32'd16 + 32'(i), 24'd0, 8'(seed + i)});
            wtag.push_back({t, " byte"});
        end
        wq.push_back({2'd1, a + 32'd12, 32'(stored)}); wtag.push_back({t, " size"});
        st = 16'h8000;
        if (n > cap) st |= 16'h0100;
        if (err)     st |= 16'h0080;
        if (n <= cap && !err) st |= 16'h2000;
        wq.push_back({2'd1, a, 16'd0, st}); wtag.push_back({t, " status"});
    endtask

    task automatic send(input int n, input int seed, input bit err);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            rx_valid = 1'b1;
            rx_data  = 8'(seed + i);
            rx_last  = (i == n - 1);
            rx_err   = err && (i == n - 1);
            while (!rx_ready) begin @(posedge clk); #1; end
        end
        @(posedge clk); #1;
        rx_valid = 1'b0; rx_last = 1'b0; rx_err = 1'b0;
    endtask

    task automatic command(input logic [2:0] c, input logic [31:0] a);
        @(posedge clk); #1;
        cmd_valid = 1'b1; cmd_code = c; cmd_addr = a;
        @(posedge clk); #1;
        cmd_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    initial begin
        for (int i = 0; i < 2048; i++) mem[i] = 8'h0;
        make_desc(32'h100, 16'h0000, 32'h200, 16'd8);
        make_desc(32'h200, 16'h0000, 32'h300, 16'd4);
        make_desc(32'h300, 16'h8000, 32'h600, 16'd8);
        make_desc(32'h400, 16'h8000, 32'h700, 16'd8);

        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        chk(ru_state == 4'd0, "R1 state", 72'(ru_state), 0);
        chk(irq_status == 8'h0, "R1 irq", 72'(irq_status), 0);
        chk(drop_cnt == 32'd0, "R1 drop count", 72'(drop_cnt), 0);
        chk(!mem_wr_en && !mem_rd_en, "R1 memory idle", 72'({mem_wr_en, mem_rd_en}), 0);

        // R11 frame while idle is discarded and counted
        chk(rx_ready == 1'b1, "R11 ready while idle", 72'(rx_ready), 1);
        send(3, 8'h50, 1'b0);
        idle(2);
        chk(drop_cnt == 32'd1, "R11 drop count idle", 72'(drop_cnt), 1);

        // R2 non-start code ignored
        command(3'd2, 32'h100);
        idle(2);
        chk(ru_state == 4'd0, "R2 other code ignored", 72'(ru_state), 0);

        // R2 R3 start
        exp_fetch(32'h100, "R3 header fetch");
        command(3'd1, 32'h100);
        chk(ru_state == 4'd4, "R2 ready after start", 72'(ru_state), 4);

        // R4 R5 good frame; R8 link fetch
        exp_frame(32'h100, 8, 5, 8'h10, 1'b0, "R5 good frame");
        exp_fetch(32'h200, "R8 link fetch");
        send(5, 8'h10, 1'b0);
        idle(10);
        chk(irq_status == 8'h40, "R10 frame irq", 72'(irq_status), 72'h40);
        chk(ru_state == 4'd4, "R8 still ready", 72'(ru_state), 4);

        // R2 start while ready ignored (a fetch at 0x500 would be unexpected)
        command(3'd1, 32'h500);
        idle(3);

        // R6 overflow truncates
        exp_frame(32'h200, 4, 6, 8'h20, 1'b0, "R6 overrun frame");
        exp_fetch(32'h300, "R8 link fetch 2");
        send(6, 8'h20, 1'b0);
        idle(10);

        // R7 error frame into end-of-chain descriptor; R9
        exp_frame(32'h300, 8, 3, 8'h30, 1'b1, "R7 short error frame");
        send(3, 8'h30, 1'b1);
        idle(10);
        chk(ru_state == 4'd2, "R9 no-resources state", 72'(ru_state), 2);
        chk(irq_status == 8'h50, "R9 no-resources irq", 72'(irq_status), 72'h50);

        // R11 dropped while no-resources
        send(2, 8'h40, 1'b0);
        idle(2);
        chk(drop_cnt == 32'd2, "R11 drop count no-resources", 72'(drop_cnt), 2);

        // R10 acknowledge frame bit
        @(posedge clk); #1; irq_ack = 8'h40;
        @(posedge clk); #1; irq_ack = 8'h00;
        chk(irq_status == 8'h10, "R10 ack clears", 72'(irq_status), 72'h10);

        // R12 restart
        exp_fetch(32'h400, "R12 restart fetch");
        command(3'd1, 32'h400);
        chk(ru_state == 4'd4, "R12 ready after restart", 72'(ru_state), 4);
        exp_frame(32'h400, 8, 2, 8'h60, 1'b0, "R12 frame after restart");
        send(2, 8'h60, 1'b0);
        idle(10);
        chk(ru_state == 4'd2, "R12 back to no-resources", 72'(ru_state), 2);
        chk(irq_status == 8'h50, "R12 irq", 72'(irq_status), 72'h50);

        chk(wq.size() == 0, "R4 pending writes", 72'(wq.size()), 0);
        chk(rq.size() == 0, "R3 pending reads", 72'(rq.size()), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule